// File: doc/BRIEF.md
# Single-Wire Capable UART Transceiver with Parity

This block is a serial transceiver for asynchronous frames. Each frame has one low start bit, a data word of 8 or 9 bits sent least significant bit first, and one high stop bit. A bit lasts 16 periods of an external oversampling tick. As an option, the top bit of the word carries a parity bit that the transmitter computes and the receiver checks. A small register port holds the configuration, the transmit and receive data, and sticky error flags. Software clears each error flag by writing a 1 to it.

In the default mode the transmitter drives `tx_o` at all times and the receiver listens on `rx_i`. When the single-wire bit is set, the block shares one open-drain line. The output enable is high only while a frame goes out. While the block sends, the receiver hears its own output internally. While the block does not send, the receiver hears the sensed pad level `pad_i`, and `rx_i` is ignored. The block never delays a transmit to avoid a collision. Two request outputs, one for transmit and one for receive, can feed a DMA engine or an interrupt controller. Each one follows its own data-ready condition and its own enable bit.

Top module: `hdx_uart`

Register map (`addr_i`). 0 is the control register (read/write). 1 is status on read and clear on write. 2 is data: a write goes to the transmit holding register and a read returns the last received word. Address 3 reads as zero.

Control bits: bit0 transmit enable, bit1 receive enable, bit2 parity enable, bit3 odd parity (0 is even), bit4 9-bit word (0 is 8-bit), bit5 single-wire mode, bit6 parity-error interrupt enable, bit7 transmit request enable, bit8 receive request enable.

Status bits: bit0 transmit holding empty, bit1 receive data ready, bit2 parity error, bit3 framing error, bit4 transmitter busy.

## Requirements
- R1: After reset, status reads 0x001, control reads 0, `tx_o`=1, `tx_oe_o`=1, and `tx_req_o`, `rx_req_o` and `irq_o` are 0.
- R2: A transmitted frame is a low start bit, then the word bits LSB first (8 bits when control bit4=0, 9 when bit4=1), then one high stop bit. Each bit lasts 16 ticks.
- R3: With parity enabled (control bit2), the word's top bit is replaced by a parity bit computed over the lower bits. With bit3=0 the total count of ones is even; with bit3=1 it is odd.
- R4: The receiver confirms a start bit 8 ticks after a falling edge and samples each bit at its middle. A low pulse shorter than half a bit produces no word. A read of address 2 returns the received word, including the parity position as received.
- R5: When parity is enabled, a received word whose parity does not match sets status bit2. `irq_o` is high while bit2 and control bit6 are both set.
- R6: Writing address 1 with bit2 set clears the parity error, and with bit3 set clears the framing error. A write with those bits at 0 leaves the flags unchanged.
- R7: A stop bit sampled low sets status bit3.
- R8: Status bit1 rises in the second half of the stop bit, before the stop bit ends.
- R9: In single-wire mode, the frames the block sends are received by its own receiver, words on the pad are received when idle, and activity on `rx_i` produces no word.
- R10: In single-wire mode, `tx_oe_o` is 0 while no frame is being sent and 1 during a frame. In full-duplex mode it stays 1.
- R11: In single-wire mode, a frame starts within two clocks of a data write with transmit enabled, even while a reception is in progress.
- R12: A data write clears status bit0. Bit0 sets again once the transmitter takes the word. A read of address 2 clears status bit1.
- R13: `tx_req_o` equals status bit0 AND control bit7. `rx_req_o` equals status bit1 AND control bit8. The two are independent.
- R14: With transmit disabled, a written word stays held (status bit0=0) and no frame is sent. The word goes out once transmit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect on data only) |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| rx_i | input | 1 | Receive pin used in full-duplex mode |
| pad_i | input | 1 | Sensed level of the shared line |
| tx_o | output | 1 | Transmit line value |
| tx_oe_o | output | 1 | Transmit output enable |
| tx_req_o | output | 1 | Transmit request |
| rx_req_o | output | 1 | Receive request |
| irq_o | output | 1 | Parity-error interrupt |

## Verification
The assertions assume a single register access per cycle. They also assume that a clear write and a frame completion do not land in the same cycle. The serial inputs are taken to be held steady for whole bit periods, with ticks evenly spaced. The stimulus fits these assumptions: the bench issues bus cycles one at a time from a single task. It drives serial bits only on falling clock edges, in 64-clock steps matched to a tick every fourth clock. It clears flags only after a frame has been fully received.

// File: rtl/hdx_uart_pkg.sv
package hdx_uart_pkg;

    localparam int CFG_W  = 9;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } ser_state_e;

    // control register, bit8 down to bit0
    typedef struct packed {
        logic rq_rx_en;
        logic rq_tx_en;
        logic perr_ie;
        logic one_wire;
        logic wide_word;
        logic par_odd;
        logic par_on;
        logic rx_on;
        logic tx_on;
    } ctrl_t;

endpackage

// File: rtl/hdx_uart_tx.sv
module hdx_uart_tx
    import hdx_uart_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_on,
    input  logic              par_on,
    input  logic              par_odd,
    input  logic              wide_word,
    input  logic              pend,
    input  logic [DATA_W-1:0] hold_word,
    output logic              take,
    output logic              line,
    output logic              busy
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        ser_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              line;
    } tx_reg_t;

    tx_reg_t q, d;
    int      word_len;

    function automatic logic [DATA_W-1:0] shape_word(
        input logic [DATA_W-1:0] din,
        input int                wl,
        input logic              pe,
        input logic              odd
    );
        logic [DATA_W-1:0] w;
        logic              p;
        w = '0;
        p = odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < wl - 1) begin
                w[i] = din[i];
                p    = p ^ din[i];
            end else if (i == wl - 1) begin
                w[i] = pe ? p : din[i];
            end
        end
        return w;
    endfunction

    always_comb begin
        d        = q;
        take     = 1'b0;
        word_len = wide_word ? DATA_W : DATA_W - 1;
        if (q.st == ST_IDLE) begin
            d.line = 1'b1;
            if (tx_on && pend) begin
                take    = 1'b1;
                d.st    = ST_START;
                d.cnt   = '0;
                d.idx   = '0;
                d.line  = 1'b0;
                d.shreg = shape_word(hold_word, word_len, par_on, par_odd);
            end
        end else if (tick) begin
            if (q.cnt == CNT_W'(OVS - 1)) begin
                d.cnt = '0;
                if (q.st == ST_START) begin
                    d.st    = ST_DATA;
                    d.idx   = '0;
                    d.line  = q.shreg[0];
                    d.shreg = q.shreg >> 1;
                end else if (q.st == ST_DATA) begin
                    if (int'(q.idx) == word_len - 1) begin
                        d.st   = ST_STOP;
                        d.line = 1'b1;
                    end else begin
                        d.idx   = q.idx + 1'b1;
                        d.line  = q.shreg[0];
                        d.shreg = q.shreg >> 1;
                    end
                end else begin
                    d.st = ST_IDLE;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.cnt   <= '0;
            q.idx   <= '0;
            q.shreg <= '0;
            q.line  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line = q.line;
    assign busy = (q.st != ST_IDLE);

    // R2: the line rests high between frames
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> q.line);

    // R14: no frame leaves while transmit is disabled
    p_hold_off_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !tx_on) |=> (q.st == ST_IDLE));

endmodule

// File: rtl/hdx_uart_rx.sv
module hdx_uart_rx
    import hdx_uart_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_on,
    input  logic              par_on,
    input  logic              par_odd,
    input  logic              wide_word,
    input  logic              ser_in,
    output logic              got_word,
    output logic [DATA_W-1:0] word,
    output logic              bad_par,
    output logic              bad_stop
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              prev;
        ser_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] bits;
        logic              done;
        logic              perr;
        logic              ferr;
    } rx_reg_t;

    rx_reg_t q, d;
    int      word_len;
    logic    fall;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.s1     = ser_in;
        d.s2     = q.s1;
        d.prev   = q.s2;
        fall     = q.prev & ~q.s2;
        word_len = wide_word ? DATA_W : DATA_W - 1;
        if (!rx_on) begin
            d.st = ST_IDLE;
        end else if (q.st == ST_IDLE) begin
            if (fall) begin
                d.st  = ST_START;
                d.cnt = '0;
            end
        end else if (tick) begin
            if (q.st == ST_START) begin
                if (q.cnt == CNT_W'(OVS / 2 - 1)) begin
                    d.cnt = '0;
                    if (!q.s2) begin
                        d.st   = ST_DATA;
                        d.idx  = '0;
                        d.bits = '0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else if (q.cnt == CNT_W'(OVS - 1)) begin
                d.cnt = '0;
                if (q.st == ST_DATA) begin
                    d.bits[q.idx] = q.s2;
                    if (int'(q.idx) == word_len - 1) begin
                        d.st = ST_STOP;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end else begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.ferr = ~q.s2;
                    d.perr = par_on && ((^q.bits) != par_odd);
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1   <= 1'b1;
            q.s2   <= 1'b1;
            q.prev <= 1'b1;
            q.st   <= ST_IDLE;
            q.cnt  <= '0;
            q.idx  <= '0;
            q.bits <= '0;
            q.done <= 1'b0;
            q.perr <= 1'b0;
            q.ferr <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign got_word = q.done;
    assign word     = q.bits;
    assign bad_par  = q.perr;
    assign bad_stop = q.ferr;

    // R8: a word is reported once, as a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R4: the word completes only out of the stop bit
    p_done_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> ($past(q.st) == ST_STOP));

endmodule

// File: rtl/hdx_uart_regs.sv
module hdx_uart_regs
    import hdx_uart_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              take,
    input  logic              tx_busy,
    input  logic              got_word,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              bad_par,
    input  logic              bad_stop,
    output logic [DATA_W-1:0] hold_word,
    output logic              pend,
    output logic              tx_on,
    output logic              rx_on,
    output logic              par_on,
    output logic              par_odd,
    output logic              wide_word,
    output logic              one_wire,
    output logic              tx_req,
    output logic              rx_req,
    output logic              irq
);
    // DATA_W is expected to be at least CFG_W

    typedef struct packed {
        ctrl_t             ctl;
        logic [DATA_W-1:0] thold;
        logic [DATA_W-1:0] rhold;
        logic              t_empty;
        logic              r_full;
        logic              perr;
        logic              ferr;
    } reg_file_t;

    reg_file_t q, d;

    always_comb begin
        d = q;
        if (take) d.t_empty = 1'b1;
        if (wr_en) begin
            case (addr)
                ADDR_CTRL: d.ctl = ctrl_t'(wdata[CFG_W-1:0]);
                ADDR_STAT: begin
                    if (wdata[2]) d.perr = 1'b0;
                    if (wdata[3]) d.ferr = 1'b0;
                end
                ADDR_DATA: begin
                    d.thold   = wdata;
                    d.t_empty = 1'b0;
                end
                default: ;
            endcase
        end
        if (rd_en && addr == ADDR_DATA) d.r_full = 1'b0;
        if (got_word) begin
            d.rhold  = rx_word;
            d.r_full = 1'b1;
            if (bad_par)  d.perr = 1'b1;
            if (bad_stop) d.ferr = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: rdata[CFG_W-1:0] = q.ctl;
            ADDR_STAT: rdata[4:0] = {tx_busy, q.ferr, q.perr, q.r_full, q.t_empty};
            ADDR_DATA: rdata = q.rhold;
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctl     <= '0;
            q.thold   <= '0;
            q.rhold   <= '0;
            q.t_empty <= 1'b1;
            q.r_full  <= 1'b0;
            q.perr    <= 1'b0;
            q.ferr    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hold_word = q.thold;
    assign pend      = ~q.t_empty;
    assign tx_on     = q.ctl.tx_on;
    assign rx_on     = q.ctl.rx_on;
    assign par_on    = q.ctl.par_on;
    assign par_odd   = q.ctl.par_odd;
    assign wide_word = q.ctl.wide_word;
    assign one_wire  = q.ctl.one_wire;
    assign tx_req    = q.ctl.rq_tx_en & q.t_empty;
    assign rx_req    = q.ctl.rq_rx_en & q.r_full;
    assign irq       = q.ctl.perr_ie & q.perr;

    // R5: a parity error only appears with a completed word
    p_perr_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.perr) |-> $past(got_word));

    // R6: a write-one clears the parity flag
    p_w1c_perr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_STAT && wdata[2] && !got_word) |=> !q.perr);

    // R13: a data write withdraws the transmit request
    p_wr_drops_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DATA) |=> !tx_req);

    // R12: reading the data drops the ready flag
    p_rd_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_DATA && !got_word) |=> !q.r_full);

endmodule

// File: rtl/hdx_uart.sv
module hdx_uart
    import hdx_uart_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              rx_i,
    input  logic              pad_i,
    output logic              tx_o,
    output logic              tx_oe_o,
    output logic              tx_req_o,
    output logic              rx_req_o,
    output logic              irq_o
);
    logic              take, tx_busy, tx_line, pend;
    logic              got_word, bad_par, bad_stop;
    logic [DATA_W-1:0] rx_word, hold_word;
    logic              tx_on, rx_on, par_on, par_odd, wide_word, one_wire;
    logic              ser_src;

    hdx_uart_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i),
        .wdata(wdata_i), .rdata(rdata_o),
        .take(take), .tx_busy(tx_busy),
        .got_word(got_word), .rx_word(rx_word),
        .bad_par(bad_par), .bad_stop(bad_stop),
        .hold_word(hold_word), .pend(pend),
        .tx_on(tx_on), .rx_on(rx_on), .par_on(par_on), .par_odd(par_odd),
        .wide_word(wide_word), .one_wire(one_wire),
        .tx_req(tx_req_o), .rx_req(rx_req_o), .irq(irq_o)
    );

    hdx_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick_i),
        .tx_on(tx_on), .par_on(par_on), .par_odd(par_odd),
        .wide_word(wide_word), .pend(pend), .hold_word(hold_word),
        .take(take), .line(tx_line), .busy(tx_busy)
    );

    // single-wire: own output while sending, pad level otherwise
    always_comb begin
        if (one_wire) ser_src = tx_busy ? tx_line : pad_i;
        else          ser_src = rx_i;
    end

    hdx_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick_i),
        .rx_on(rx_on), .par_on(par_on), .par_odd(par_odd),
        .wide_word(wide_word), .ser_in(ser_src),
        .got_word(got_word), .word(rx_word),
        .bad_par(bad_par), .bad_stop(bad_stop)
    );

    assign tx_o    = tx_line;
    assign tx_oe_o = one_wire ? tx_busy : 1'b1;

    // R10: a low level is never left undriven on the shared line
    p_hd_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (one_wire && !tx_o) |-> tx_oe_o);

endmodule

// File: tb/hdx_uart_tb.sv
module hdx_uart_tb;
    localparam int DW   = 9;
    localparam int TPER = 4;
    localparam int BIT  = 16 * TPER;

    localparam logic [8:0] C_TX = 9'h001, C_RX = 9'h002, C_PE = 9'h004, C_ODD = 9'h008,
                           C_LONG = 9'h010, C_HD = 9'h020, C_PIE = 9'h040,
                           C_DTX = 9'h080, C_DRX = 9'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [1:0]    addr_i = 2'd1;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          rx_i = 1'b1, pad_i = 1'b1;
    logic          tx_o, tx_oe_o, tx_req_o, rx_req_o, irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [8:0] exq[$];
    int         exl[$];

    hdx_uart #(.DATA_W(DW), .OVS(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o),
        .rx_i(rx_i), .pad_i(pad_i),
        .tx_o(tx_o), .tx_oe_o(tx_oe_o),
        .tx_req_o(tx_req_o), .rx_req_o(rx_req_o), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            repeat (TPER - 1) @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [8:0] v);
        @(negedge clk);
        addr_i = a; wdata_i = v; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; addr_i = 2'd1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [8:0] v);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        #1 v = rdata_o;
        @(negedge clk);
        rd_en_i = 1'b0; addr_i = 2'd1;
    endtask

    task automatic peek(output logic [8:0] v);
        v = rdata_o;
    endtask

    function automatic logic [8:0] expect_word(input logic [8:0] v, input int len,
                                               input bit pe, input bit odd);
        logic [8:0] w;
        logic p;
        w = '0; p = odd;
        for (int i = 0; i < 9; i++) begin
            if (i < len - 1) begin w[i] = v[i]; p = p ^ v[i]; end
            else if (i == len - 1) w[i] = pe ? p : v[i];
        end
        return w;
    endfunction

    task automatic send(input logic [8:0] v, input int len, input bit pe, input bit odd);
        exq.push_back(expect_word(v, len, pe, odd));
        exl.push_back(len);
        wr(2'd2, v);
    endtask

    task automatic set_line(input bit use_pad, input logic v);
        if (use_pad) pad_i = v; else rx_i = v;
    endtask

    task automatic drive_rx(input logic [8:0] b, input int len, input logic stopv,
                            input bit use_pad, input bit midchk);
        logic [8:0] s;
        @(negedge clk);
        set_line(use_pad, 1'b0);
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            set_line(use_pad, b[i]);
            repeat (BIT) @(negedge clk);
        end
        set_line(use_pad, stopv);
        if (midchk) begin
            repeat (24) @(negedge clk);
            peek(s);
            chk("R8 ready not before mid stop", {31'd0, s[1]}, 32'd0);
            repeat (24) @(negedge clk);
            peek(s);
            chk("R8 ready before stop end", {31'd0, s[1]}, 32'd1);
            repeat (BIT - 48) @(negedge clk);
        end else begin
            repeat (BIT) @(negedge clk);
        end
        set_line(use_pad, 1'b1);
        repeat (BIT) @(negedge clk);
    endtask

    // scoreboard monitor for the transmit line (R2, R3)
    initial begin
        forever begin
            logic [8:0] got, exp;
            int len;
            @(negedge tx_o);
            if (exq.size() == 0) begin
                total++; bad++;
                $display("FAIL R2 unexpected frame act=1 exp=0");
                exp = '0; len = 8;
            end else begin
                exp = exq.pop_front();
                len = exl.pop_front();
            end
            repeat (BIT / 2) @(negedge clk);
            chk("R2 start bit", {31'd0, tx_o}, 32'd0);
            got = '0;
            for (int i = 0; i < len; i++) begin
                repeat (BIT) @(negedge clk);
                got[i] = tx_o;
            end
            chk("R2 R3 frame word", {23'd0, got}, {23'd0, exp});
            repeat (BIT) @(negedge clk);
            chk("R2 stop bit", {31'd0, tx_o}, 32'd1);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam int FRAME = 12 * BIT;

    initial begin
        logic [8:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(v);
        chk("R1 status", {23'd0, v}, 32'h001);
        rd(2'd0, v);
        chk("R1 control", {23'd0, v}, 32'h000);
        chk("R1 tx_o", {31'd0, tx_o}, 32'd1);
        chk("R1 tx_oe", {31'd0, tx_oe_o}, 32'd1);
        chk("R1 requests", {29'd0, tx_req_o, rx_req_o, irq_o}, 32'd0);

        // R14 / R12 hold while transmit disabled
        send(9'h042, 8, 0, 0);
        repeat (300) @(negedge clk);
        chk("R14 line idle", {31'd0, tx_o}, 32'd1);
        peek(v);
        chk("R12 R14 word held", {31'd0, v[0]}, 32'd0);
        wr(2'd0, C_TX);
        repeat (6) @(negedge clk);
        peek(v);
        chk("R12 empty after take, busy", {30'd0, v[4], v[0]}, 32'd3);
        repeat (FRAME) @(negedge clk);

        // R2 9-bit word
        wr(2'd0, C_TX | C_LONG);
        send(9'h1C3, 9, 0, 0);
        repeat (FRAME) @(negedge clk);

        // R3 parity variants
        wr(2'd0, C_TX | C_PE);
        send(9'h0FF, 8, 1, 0);
        repeat (FRAME) @(negedge clk);
        send(9'h003, 8, 1, 0);
        repeat (FRAME) @(negedge clk);
        wr(2'd0, C_TX | C_PE | C_ODD);
        send(9'h003, 8, 1, 1);
        repeat (FRAME) @(negedge clk);
        wr(2'd0, C_TX | C_PE | C_ODD | C_LONG);
        send(9'h0FF, 9, 1, 1);
        repeat (FRAME) @(negedge clk);

        // R12 back-to-back through the holding register
        wr(2'd0, C_TX);
        send(9'h0A5, 8, 0, 0);
        repeat (4) @(negedge clk);
        send(9'h05A, 8, 0, 0);
        @(negedge clk);
        peek(v);
        chk("R12 second word held", {31'd0, v[0]}, 32'd0);
        repeat (2 * FRAME) @(negedge clk);

        // R4 / R8 reception
        wr(2'd0, C_RX);
        drive_rx(9'h03C, 8, 1'b1, 0, 1);
        rd(2'd2, v);
        chk("R4 received word", {23'd0, v}, 32'h03C);
        peek(v);
        chk("R12 read clears ready", {31'd0, v[1]}, 32'd0);
        wr(2'd0, C_RX | C_LONG);
        drive_rx(9'h155, 9, 1'b1, 0, 0);
        rd(2'd2, v);
        chk("R4 received 9-bit", {23'd0, v}, 32'h155);

        // R4 short glitch rejected
        @(negedge clk); rx_i = 1'b0;
        repeat (12) @(negedge clk); rx_i = 1'b1;
        repeat (FRAME) @(negedge clk);
        peek(v);
        chk("R4 glitch gives no word", {31'd0, v[1]}, 32'd0);

        // R5 / R6 parity error and clearing
        wr(2'd0, C_RX | C_PE | C_PIE);
        drive_rx(9'h001, 8, 1'b1, 0, 0);
        peek(v);
        chk("R5 parity error flag", {31'd0, v[2]}, 32'd1);
        chk("R5 irq", {31'd0, irq_o}, 32'd1);
        rd(2'd2, v);
        chk("R4 word with parity position", {23'd0, v}, 32'h001);
        wr(2'd1, 9'h000);
        peek(v);
        chk("R6 zero write keeps flag", {31'd0, v[2]}, 32'd1);
        wr(2'd1, 9'h004);
        peek(v);
        chk("R6 clear parity flag", {31'd0, v[2]}, 32'd0);
        chk("R6 irq drops", {31'd0, irq_o}, 32'd0);
        drive_rx(9'h081, 8, 1'b1, 0, 0);
        peek(v);
        chk("R5 good parity no flag", {31'd0, v[2]}, 32'd0);
        rd(2'd2, v);

        // R7 framing error
        wr(2'd0, C_RX);
        drive_rx(9'h066, 8, 1'b0, 0, 0);
        peek(v);
        chk("R7 framing flag", {31'd0, v[3]}, 32'd1);
        wr(2'd1, 9'h008);
        peek(v);
        chk("R6 clear framing flag", {31'd0, v[3]}, 32'd0);
        rd(2'd2, v);

        // R13 independent requests
        wr(2'd0, C_RX | C_DTX);
        chk("R13 tx request", {30'd0, tx_req_o, rx_req_o}, 32'd2);
        drive_rx(9'h011, 8, 1'b1, 0, 0);
        chk("R13 rx request off", {31'd0, rx_req_o}, 32'd0);
        wr(2'd0, C_RX | C_DRX);
        chk("R13 rx request on", {30'd0, tx_req_o, rx_req_o}, 32'd1);
        rd(2'd2, v);
        chk("R13 rx request after read", {31'd0, rx_req_o}, 32'd0);

        // R9 / R10 single-wire mode
        wr(2'd0, C_HD | C_TX | C_RX);
        repeat (4) @(negedge clk);
        chk("R10 released when idle", {31'd0, tx_oe_o}, 32'd0);
        drive_rx(9'h055, 8, 1'b1, 0, 0);
        peek(v);
        chk("R9 rx pin ignored", {31'd0, v[1]}, 32'd0);
        send(9'h05A, 8, 0, 0);
        repeat (BIT) @(negedge clk);
        chk("R10 driven during frame", {31'd0, tx_oe_o}, 32'd1);
        repeat (FRAME) @(negedge clk);
        chk("R10 released after frame", {31'd0, tx_oe_o}, 32'd0);
        rd(2'd2, v);
        chk("R9 loopback word", {23'd0, v}, 32'h05A);
        drive_rx(9'h096, 8, 1'b1, 1, 0);
        rd(2'd2, v);
        chk("R9 pad word", {23'd0, v}, 32'h096);

        // R11 no blocking during reception
        fork
            drive_rx(9'h033, 8, 1'b1, 1, 0);
            begin
                repeat (200) @(negedge clk);
                send(9'h00F, 8, 0, 0);
                repeat (2) @(negedge clk);
                chk("R11 frame starts during reception", {31'd0, tx_oe_o}, 32'd1);
            end
        join
        repeat (FRAME) @(negedge clk);
        wr(2'd1, 9'h00C);
        rd(2'd2, v);

        chk("R2 all frames seen", exq.size(), 32'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule